// File: doc/BRIEF.md
# SPI Slave Port with Buffer Policies

This block is the slave side of an SPI link for a system-clocked core. The SPI clock, the MOSI line and the active-low select are brought into the system clock domain through a short flop chain. A word is then shifted in on MOSI and out on MISO, most significant bit first. The word is 8 or 16 bits wide. The sampling and driving edges follow the clock polarity and phase inputs, which must match the mode the master uses. Each falling edge of select frames exactly one word. SCK activity after the last bit of that word is ignored until select rises and falls again.

The core supplies outgoing words through a valid/ready stream into a single-entry transmit register. Received words leave through a valid/ready stream out of a single-entry receive register. A transmit handshake completes only while the transmit register is empty (`tx_ready` high), so the core has to wait for the shifter to take the previous word. A receive handshake completes on any cycle where `rx_valid` and `rx_ready` are both high. The shifter never waits for either side. If the core has not supplied a word in time, `send_zero` selects between sending zeros and resending the last word. If the core has not taken the previous word in time, `get_more` selects between overwriting it and dropping the new word. In both receive cases a sticky overrun flag is raised.

The system clock must run at least four times faster than SCK. For MISO timing, half an SCK period must also cover the three-cycle path from an SCK edge to MISO. The mode inputs must be held steady while select is low.

Top module: `spi_slv_port`

## Requirements
- R1: A word starts on each falling edge of the synchronized select. Once a full word has been sampled, further SCK edges are ignored until select rises and falls again. They neither start a word nor raise overrun.
- R2: With `cpol` giving the idle SCK level, the leading edge is the first edge away from idle. With `cpha`=0, MOSI is sampled on leading edges and MISO changes on trailing edges. With `cpha`=1, MISO changes on leading edges (after the first) and MOSI is sampled on trailing edges. Bits travel MSB first.
- R3: `wide`=1 selects 16-bit words. `wide`=0 selects 8-bit words, carried in bits [7:0] of `tx_data`/`rx_data`, with `rx_data[15:8]` reading 0.
- R4: If select rises before a full word has been sampled, the partial word is dropped and the receive side is unchanged.
- R5: A word that starts while the transmit register is empty and `send_zero`=1 is sent as all zeros.
- R6: A word that starts while the transmit register is empty and `send_zero`=0 repeats the last word sent.
- R7: When a word completes while the receive register is full and `get_more`=1, the new word replaces the held one.
- R8: When a word completes while the receive register is full and `get_more`=0, the new word is dropped and `rx_data` keeps its value.
- R9: `overrun` is set when a word completes into a full receive register that is not being read in that cycle. This happens under either `get_more` setting. A one-cycle pulse on `overrun_clr` clears it, and setting wins over clearing.
- R10: `tx_ready` and `tx_empty` are high exactly while the transmit register is empty. An accepted word is loaded into the shifter at the next word start, which empties the register.
- R11: `rx_valid` (and `rx_full`) are high while the receive register holds a word. A handshake empties it, unless a new word completes in the same cycle, in which case the new word is stored without overrun.
- R12: `spi_miso_oe` is high only while the synchronized select is low. `spi_miso` is 0 whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| send_zero | input | 1 | Empty-transmit policy: 1 zeros, 0 repeat last |
| get_more | input | 1 | Full-receive policy: 1 overwrite, 0 drop |
| spi_sck | input | 1 | SPI clock from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO output enable |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit register empty, word will be taken |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Receive register holds a word |
| rx_ready | input | 1 | Core takes the received word |
| rx_data | output | 16 | Received word |
| tx_empty | output | 1 | Transmit register empty flag |
| rx_full | output | 1 | Receive register full flag |
| overrun | output | 1 | Sticky receive overrun flag |
| overrun_clr | input | 1 | Pulse to clear overrun |

## Verification
The link is exercised in all four polarity/phase combinations, with both word sizes and with asymmetric data patterns. This shows that the sampling edge, the driving edge and the MSB-first order are each right, and that no bit is missed. Words are sent with the transmit register left empty under both policy settings, so the zero fill and the repeat of the last word can be told apart from a stale register. Words are also sent into a receive register that has not been read, under both policy settings, to separate overwrite from drop and to confirm that overrun is set and cleared. A word cut short by select and a word followed by surplus SCK pulses show that only complete, single words reach the receive side.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic wide;
  } link_mode_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
  import spi_slv_pkg::*;
#(
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  link_mode_t        mode,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              ss_n_s,
  input  logic [LONG_W-1:0] load_word,
  output logic              word_start,
  output logic              word_done,
  output logic [LONG_W-1:0] rx_word,
  output logic              miso,
  output logic              miso_oe
);
  localparam int unsigned CW = $clog2(LONG_W + 1);

  logic              ss_q, sck_q, active;
  logic [CW-1:0]     cnt, nbits;
  logic [LONG_W-1:0] tx_sh, rx_sh;
  logic              sck_rise, sck_fall, lead_edge, trail_edge;
  logic              sample_edge, drive_edge;

  assign nbits      = mode.wide ? CW'(LONG_W) : CW'(SHORT_W);
  assign sck_rise   = sck_s & ~sck_q;
  assign sck_fall   = ~sck_s & sck_q;
  assign lead_edge  = mode.cpol ? sck_fall : sck_rise;
  assign trail_edge = mode.cpol ? sck_rise : sck_fall;
  assign sample_edge = mode.cpha ? trail_edge : lead_edge;
  assign drive_edge  = mode.cpha ? lead_edge  : trail_edge;
  assign word_start  = ss_q & ~ss_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q      <= 1'b1;
      sck_q     <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      word_done <= 1'b0;
      rx_word   <= '0;
    end else begin
      ss_q      <= ss_n_s;
      sck_q     <= sck_s;
      word_done <= 1'b0;
      if (word_start) begin
        active <= 1'b1;
        cnt    <= '0;
        tx_sh  <= load_word;
        rx_sh  <= '0;
      end else if (ss_n_s) begin
        active <= 1'b0;
      end else if (active) begin
        if (sample_edge) begin
          rx_sh <= {rx_sh[LONG_W-2:0], mosi_s};
          cnt   <= cnt + 1'b1;
          if (cnt == nbits - 1'b1) begin
            active    <= 1'b0;
            word_done <= 1'b1;
            rx_word   <= {rx_sh[LONG_W-2:0], mosi_s};
          end
        end
        if (drive_edge && (!mode.cpha || cnt != '0))
          tx_sh <= {tx_sh[LONG_W-2:0], 1'b0};
      end
    end
  end

  assign miso_oe = ~ss_n_s;
  assign miso    = ss_n_s ? 1'b0 : (mode.wide ? tx_sh[LONG_W-1] : tx_sh[SHORT_W-1]);

  assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < nbits));
  assert_single_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !active);
  assert_short_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !mode.wide) |-> (rx_word[LONG_W-1:SHORT_W] == '0));
endmodule

// File: rtl/spi_slv_txbuf.sv
module spi_slv_txbuf #(
  parameter int unsigned LONG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [LONG_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              send_zero,
  input  logic              start,
  output logic [LONG_W-1:0] load_word
);
  logic              held;
  logic [LONG_W-1:0] hold_reg, last_sent;

  assign wr_ready  = ~held;
  assign load_word = held ? hold_reg : (send_zero ? '0 : last_sent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      hold_reg  <= '0;
      last_sent <= '0;
    end else begin
      if (start) begin
        last_sent <= load_word;
        held      <= 1'b0;
      end
      if (wr_valid && wr_ready) begin
        hold_reg <= wr_data;
        held     <= 1'b1;
      end
    end
  end

  assert_take_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && held) |=> !held);
  assert_accept_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !held && send_zero) |=> (last_sent == '0));
endmodule

// File: rtl/spi_slv_rxbuf.sv
module spi_slv_rxbuf #(
  parameter int unsigned LONG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [LONG_W-1:0] word,
  input  logic              get_more,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [LONG_W-1:0] rd_data,
  input  logic              ovr_clr,
  output logic              overrun
);
  logic pop;
  assign pop = rd_valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (done) begin
        if (!rd_valid || pop) begin
          rd_data  <= word;
          rd_valid <= 1'b1;
        end else if (get_more) begin
          rd_data <= word;
        end
      end else if (pop) begin
        rd_valid <= 1'b0;
      end
      if (done && rd_valid && !pop) overrun <= 1'b1;
      else if (ovr_clr)             overrun <= 1'b0;
    end
  end

  assert_drop_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_valid && !pop && !get_more) |=> $stable(rd_data));
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_valid && !pop) |=> overrun);
  assert_pop_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !done) |=> !rd_valid);
  assert_done_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_valid);
endmodule

// File: rtl/spi_slv_port.sv
module spi_slv_port
  import spi_slv_pkg::*;
#(
  parameter int unsigned LONG_W      = 16,
  parameter int unsigned SHORT_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              wide,
  input  logic              send_zero,
  input  logic              get_more,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [LONG_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [LONG_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  input  logic              overrun_clr
);
  logic [2:0]        pins_s;
  logic              start, done;
  logic [LONG_W-1:0] load_word, rx_word;
  link_mode_t        mode;

  assign mode = '{cpol: cpol, cpha: cpha, wide: wide};

  spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_ss_n, spi_mosi, spi_sck}), .q(pins_s)
  );

  spi_slv_engine #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .sck_s(pins_s[0]), .mosi_s(pins_s[1]), .ss_n_s(pins_s[2]),
    .load_word(load_word), .word_start(start), .word_done(done),
    .rx_word(rx_word), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_slv_txbuf #(.LONG_W(LONG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(tx_valid), .wr_data(tx_data),
    .wr_ready(tx_ready), .send_zero(send_zero), .start(start),
    .load_word(load_word)
  );

  spi_slv_rxbuf #(.LONG_W(LONG_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .done(done), .word(rx_word),
    .get_more(get_more), .rd_ready(rx_ready), .rd_valid(rx_valid),
    .rd_data(rx_data), .ovr_clr(overrun_clr), .overrun(overrun)
  );

  assign tx_empty = tx_ready;
  assign rx_full  = rx_valid;

  assert_oe_follows_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_s[2]) |-> !spi_miso_oe);
endmodule

// File: tb/spi_slv_port_test.sv
`timescale 1ns/1ps
module spi_slv_port_test;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0;
  logic cpol = 0, cpha = 0, wide = 0, send_zero = 0, get_more = 0;
  logic spi_sck = 0, spi_mosi = 0, spi_ss_n = 1;
  logic spi_miso, spi_miso_oe;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic [15:0] tx_data = 0, rx_data;
  logic tx_empty, rx_full, overrun, overrun_clr = 0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  spi_slv_port uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .wide(wide),
    .send_zero(send_zero), .get_more(get_more), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
    .overrun(overrun), .overrun_clr(overrun_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each receive handshake
  always @(posedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected word", rx_data, 16'h0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = exp_tag.pop_front();
        chk(rx_data == e, t, rx_data, e);
      end
    end
  end

  task automatic wait_h(); repeat (HALF) @(negedge clk); endtask

  task automatic set_mode(input logic pol, input logic pha, input logic w);
    @(negedge clk); cpol = pol; cpha = pha; wide = w; spi_sck = pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_tx(input logic [15:0] d, input string tag);
    @(negedge clk);
    chk(tx_ready == 1'b1, tag, {15'b0, tx_ready}, 16'h1);
    tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
    chk(tx_empty == 1'b0, tag, {15'b0, tx_empty}, 16'h0);
  endtask

  task automatic xfer(input logic [15:0] mo, input int n, input int extra, output logic [15:0] mi);
    mi = 0;
    @(negedge clk); spi_ss_n = 0; spi_sck = cpol;
    wait_h();
    for (int i = n - 1; i >= 0; i--) begin
      if (!cpha) begin
        spi_mosi = mo[i]; wait_h(); mi = {mi[14:0], spi_miso};
        spi_sck = ~cpol; wait_h(); spi_sck = cpol;
      end else begin
        spi_sck = ~cpol; spi_mosi = mo[i]; wait_h(); mi = {mi[14:0], spi_miso};
        spi_sck = cpol; wait_h();
      end
    end
    if (!cpha) wait_h();
    for (int k = 0; k < extra; k++) begin
      spi_mosi = 1; spi_sck = ~cpol; wait_h(); spi_sck = cpol; wait_h();
    end
    spi_ss_n = 1; wait_h(); wait_h();
  endtask

  task automatic drain();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic clr_ovr();
    @(negedge clk); overrun_clr = 1;
    @(negedge clk); overrun_clr = 0;
  endtask

  task automatic mode_word(input logic pol, input logic pha, input logic w,
                           input logic [15:0] txw, input logic [15:0] mow, input string tag);
    logic [15:0] mi, m;
    int n;
    n = w ? 16 : 8;
    m = w ? 16'hFFFF : 16'h00FF;
    set_mode(pol, pha, w);
    push_tx(txw, {tag, " R10 accept"});
    xfer(mow, n, 0, mi);
    chk(mi == (txw & m), {tag, " R2 miso word"}, mi, txw & m);
    chk(tx_empty == 1'b1, {tag, " R10 emptied"}, {15'b0, tx_empty}, 16'h1);
    exp_q.push_back(mow & m); exp_tag.push_back({tag, " R2 mosi word"});
    drain();
  endtask

  initial begin
    logic [15:0] mi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_empty && tx_ready, "R10 reset tx empty", {15'b0, tx_empty}, 16'h1);
    chk(!rx_valid && !rx_full, "R11 reset rx empty", {15'b0, rx_valid}, 16'h0);
    chk(!overrun, "R9 reset overrun", {15'b0, overrun}, 16'h0);
    chk(!spi_miso_oe && !spi_miso, "R12 idle miso", {14'b0, spi_miso_oe, spi_miso}, 16'h0);

    mode_word(0, 0, 0, 16'h00A5, 16'h003C, "mode0 8b R3");
    mode_word(0, 1, 1, 16'h1234, 16'hBEEF, "mode1 16b R3");
    mode_word(1, 0, 1, 16'h8001, 16'h4C71, "mode2 16b");
    mode_word(1, 1, 0, 16'h0096, 16'h00E1, "mode3 8b");

    // R12: enable follows select
    @(negedge clk); spi_ss_n = 0; repeat (5) @(negedge clk);
    chk(spi_miso_oe == 1'b1, "R12 oe while selected", {15'b0, spi_miso_oe}, 16'h1);
    spi_ss_n = 1; repeat (5) @(negedge clk);
    chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R12 released", {14'b0, spi_miso_oe, spi_miso}, 16'h0);

    // R6: empty transmit repeats last word (last loaded was 0x96)
    set_mode(0, 0, 0); send_zero = 0;
    xfer(16'h0011, 8, 0, mi);
    chk(mi == 16'h0096, "R6 repeat last", mi, 16'h0096);
    xfer(16'h0022, 8, 0, mi);
    chk(mi == 16'h0096, "R6 repeat again", mi, 16'h0096);
    exp_q.push_back(16'h0011); exp_tag.push_back("R6 rx first");
    drain();
    // second word went into a full register, get_more=0: dropped, overrun set
    chk(overrun == 1'b1, "R9 overrun after repeat", {15'b0, overrun}, 16'h1);
    clr_ovr();

    // R5: empty transmit sends zeros
    send_zero = 1;
    xfer(16'h0055, 8, 0, mi);
    chk(mi == 16'h0000, "R5 zero fill", mi, 16'h0000);
    exp_q.push_back(16'h0055); exp_tag.push_back("R5 rx word");
    drain();

    // R1: surplus SCK pulses after a full word are ignored
    xfer(16'h0081, 8, 12, mi);
    chk(rx_valid == 1'b1 && rx_data == 16'h0081, "R1 word kept", rx_data, 16'h0081);
    chk(overrun == 1'b0, "R1 no extra word", {15'b0, overrun}, 16'h0);
    exp_q.push_back(16'h0081); exp_tag.push_back("R1 rx word");
    drain();

    // R4: aborted word is dropped
    xfer(16'h001F, 5, 0, mi);
    chk(rx_valid == 1'b0, "R4 partial dropped", {15'b0, rx_valid}, 16'h0);
    chk(overrun == 1'b0, "R4 no overrun", {15'b0, overrun}, 16'h0);

    // R8: full receive register, drop policy
    get_more = 0;
    xfer(16'h00C3, 8, 0, mi);
    xfer(16'h0042, 8, 0, mi);
    chk(rx_data == 16'h00C3, "R8 keeps old", rx_data, 16'h00C3);
    chk(overrun == 1'b1, "R9 set on drop", {15'b0, overrun}, 16'h1);
    clr_ovr();
    chk(overrun == 1'b0, "R9 cleared", {15'b0, overrun}, 16'h0);
    exp_q.push_back(16'h00C3); exp_tag.push_back("R8 rx old");
    drain();

    // R7: full receive register, overwrite policy
    get_more = 1;
    set_mode(0, 1, 1);
    xfer(16'h1357, 16, 0, mi);
    xfer(16'hA9CE, 16, 0, mi);
    chk(rx_data == 16'hA9CE, "R7 overwrite", rx_data, 16'hA9CE);
    chk(overrun == 1'b1, "R9 set on overwrite", {15'b0, overrun}, 16'h1);
    clr_ovr();
    exp_q.push_back(16'hA9CE); exp_tag.push_back("R7 rx new");
    drain();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 scoreboard drained", 16'(exp_q.size()), 16'h0);
    chk(rx_valid == 1'b0, "R11 empty after read", {15'b0, rx_valid}, 16'h0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule